// File: doc/BRIEF.md
# Frequency-Banded Adaptive FIR Ripple Filter

This block removes ripple from a signal in the rotating reference frame of a grid-synchronisation loop. When the supply is unbalanced, a ripple at twice the fundamental appears in that frame. Fifth and seventh harmonics add a ripple at six times the fundamental. A filter whose nulls are fixed at the nominal frequency stops removing these ripples once the supply drifts. Here the nulls follow the measured fundamental instead.

Each input sample arrives with a valid strobe. The block also receives the current frequency estimate. From that estimate it derives a band index, with hysteresis at the band edges. The band selects one of fourteen precomputed coefficient sets in a ROM. Each set is a symmetric, linear-phase window that spans about one period of its band's centre frequency, so the response has nulls at the fundamental and at all of its integer multiples.

The selected set passes through a shadow register bank into an active bank. The active bank is reloaded only at the edge that accepts a sample. A single multiplier then walks the 32-tap symmetric filter, one pre-added tap pair per cycle. The result is rounded and saturated to 16 bits.

Top module: `afir_ripple_filter`

## Requirements
- R1: `freq_i` is an unsigned frequency in 1/256 Hz units. The raw band is floor((f − 20 Hz) / 3 Hz), forced to 0 below 20 Hz and to 13 at 59 Hz and above, which gives bands 0 to 13.
- R2: The held band changes to the raw band only when f falls more than 0.25 Hz (64 LSB) below the held band's lower edge, or reaches 0.25 Hz or more above its upper edge. The lower-edge test is skipped for band 0 and the upper-edge test for band 13. A constant `freq_i` therefore never causes more than one band change.
- R3: The coefficient set for band b has a half-width hw = floor((2·640 + c) / (2·c)), where c = 43 + 6b is the band centre in half-Hz units; hw is clamped to the range 1..16. Taps 16−hw through 15+hw each weigh floor(32768 / (2·hw)) and all other taps weigh zero. Tap 0 holds the newest sample.
- R4: The output is floor((S + 16384) / 32768), saturated to the range −32768..32767, where S is the exact sum over all taps of sample times weight.
- R5: The coefficient set used for an output is the one selected by the band held two or more cycles before the accepting edge. `out_band_o` reports that set's band from the accepting edge onward. A change of `freq_i` after the accepting edge does not alter that output.
- R6: `out_valid_o` is a one-cycle pulse that rises on the 17th rising edge after the edge that accepted `samp_valid_i`. Successive samples must be at least 18 cycles apart.
- R7: Once the taps that carry weight hold a zero-mean sequence whose period is 2·hw, or 2·hw divided by an integer, the output is exactly 0.
- R8: While reset is asserted, `out_valid_o`, `out_data_o` and `out_band_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| freq_i | input | 16 | Supply frequency estimate, 1/256 Hz per LSB |
| samp_valid_i | input | 1 | Strobe marking a new input sample |
| samp_i | input | 16 | Signed input sample |
| out_valid_o | output | 1 | One-cycle strobe marking a new filtered output |
| out_data_o | output | 16 | Signed filtered output |
| out_band_o | output | 4 | Band of the coefficient set behind the current output |

## Verification
Each fault shows up at the ports on the next output strobe. A wrong held band or a failed swap appears as a wrong `out_band_o`, because that band is latched at the accepting edge. A corrupted coefficient bank, a misaligned tap pair or a bad rounding step appears as a mismatch in `out_data_o` 17 cycles after the sample is accepted. The impulse and constant inputs show the weights tap by tap. The periodic zero-mean inputs show misplaced nulls as a nonzero output once the window has filled.

// File: rtl/afir_pkg.sv
package afir_pkg;

  // Half-width of the rectangular window for one band (clamped 1..half).
  function automatic int afir_half_win(int band, int half, int fs_hz,
                                       int fmin_hz, int step_hz);
    int ctr2;
    int hw;
    ctr2 = 2 * fmin_hz + 2 * step_hz * band + step_hz;
    hw   = (2 * fs_hz + ctr2) / (2 * ctr2);
    if (hw < 1)    hw = 1;
    if (hw > half) hw = half;
    return hw;
  endfunction

  // Weight of half-index k (tap k and its mirror) for one band.
  function automatic int afir_coef(int band, int k, int half, int fs_hz,
                                   int fmin_hz, int step_hz, int cw);
    int hw;
    hw = afir_half_win(band, half, fs_hz, fmin_hz, step_hz);
    if (k >= half - hw) return (1 << (cw - 1)) / (2 * hw);
    return 0;
  endfunction

endpackage

// File: rtl/afir_band_sel.sv
module afir_band_sel #(
  parameter int FW       = 16,
  parameter int FRAC     = 8,
  parameter int NBANDS   = 14,
  parameter int F_MIN_HZ = 20,
  parameter int BAND_HZ  = 3,
  parameter int HYST_Q   = 64,
  parameter int BW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] freq_i,
  output logic [BW-1:0] band_o
);
  localparam logic [31:0] BASE_Q = 32'(F_MIN_HZ << FRAC);
  localparam logic [31:0] STEP_Q = 32'(BAND_HZ << FRAC);
  localparam logic [31:0] HYST   = 32'(HYST_Q);
  localparam logic [BW-1:0] TOP  = BW'(NBANDS - 1);

  logic [31:0]   fz;
  logic [31:0]   lo_edge;
  logic [BW-1:0] raw_band;
  logic [BW-1:0] band_q, band_d;
  logic          leave_lo, leave_hi;

  assign fz = 32'(freq_i);

  always_comb begin
    raw_band = '0;
    for (int k = 1; k < NBANDS; k++) begin
      if (fz >= BASE_Q + 32'(k) * STEP_Q) raw_band = BW'(k);
    end
  end

  assign lo_edge  = BASE_Q + 32'(band_q) * STEP_Q;
  assign leave_lo = (band_q != '0) && (fz + HYST < lo_edge);
  assign leave_hi = (band_q != TOP) && (fz >= lo_edge + STEP_Q + HYST);

  always_comb begin
    band_d = band_q;
    if (leave_lo || leave_hi) band_d = raw_band;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) band_q <= '0;
    else        band_q <= band_d;
  end

  assign band_o = band_q;
endmodule

// File: rtl/afir_coef_bank.sv
module afir_coef_bank #(
  parameter int NBANDS    = 14,
  parameter int HALF      = 16,
  parameter int CW        = 16,
  parameter int SAMPLE_HZ = 640,
  parameter int F_MIN_HZ  = 20,
  parameter int BAND_HZ   = 3,
  parameter int BW        = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BW-1:0]        band_i,
  input  logic                 load_i,
  output logic signed [CW-1:0] coef_o [HALF],
  output logic [BW-1:0]        band_o
);
  logic signed [CW-1:0] rom      [NBANDS][HALF];
  logic signed [CW-1:0] shadow_q [HALF];
  logic signed [CW-1:0] active_q [HALF];
  logic [BW-1:0]        sel;
  logic [BW-1:0]        sh_band_q, act_band_q;

  for (genvar b = 0; b < NBANDS; b++) begin : g_band
    for (genvar k = 0; k < HALF; k++) begin : g_tap
      assign rom[b][k] = CW'(afir_pkg::afir_coef(b, k, HALF, SAMPLE_HZ,
                                                 F_MIN_HZ, BAND_HZ, CW));
    end
  end

  assign sel = (band_i < BW'(NBANDS)) ? band_i : BW'(NBANDS - 1);

  // Shadow bank follows the selected band every cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_band_q <= '0;
      for (int k = 0; k < HALF; k++) shadow_q[k] <= '0;
    end else begin
      sh_band_q <= sel;
      for (int k = 0; k < HALF; k++) shadow_q[k] <= rom[sel][k];
    end
  end

  // Active bank changes only at a sample boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_band_q <= '0;
      for (int k = 0; k < HALF; k++) active_q[k] <= '0;
    end else if (load_i) begin
      act_band_q <= sh_band_q;
      for (int k = 0; k < HALF; k++) active_q[k] <= shadow_q[k];
    end
  end

  assign coef_o = active_q;
  assign band_o = act_band_q;
endmodule

// File: rtl/afir_mac.sv
module afir_mac #(
  parameter int TAPS = 32,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int AW   = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 samp_valid_i,
  input  logic signed [DW-1:0] samp_i,
  input  logic signed [CW-1:0] coef_i [TAPS/2],
  output logic                 out_valid_o,
  output logic signed [DW-1:0] out_o
);
  localparam int HALF = TAPS / 2;
  localparam int IW   = $clog2(HALF);
  localparam int PW   = DW + 1 + CW;
  localparam int SH   = CW - 1;
  localparam logic signed [AW-1:0] RND  = {{(AW-SH){1'b0}}, 1'b1, {(SH-1){1'b0}}};
  localparam logic signed [AW-1:0] OMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] OMIN = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};
  localparam logic [IW-1:0] LAST = IW'(HALF - 1);

  logic signed [DW-1:0] dly_q [TAPS];
  logic                 busy_q, busy_d, fin_q, fin_d, ov_q, ov_d;
  logic [IW-1:0]        idx_q, idx_d;
  logic signed [AW-1:0] acc_q, acc_d, rnd_s;
  logic signed [DW-1:0] out_q, out_d, tap_a, tap_b;
  logic signed [DW:0]   pre;
  logic signed [PW-1:0] prod;

  // Delay line: tap 0 is the newest sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) dly_q[i] <= '0;
    end else if (samp_valid_i) begin
      dly_q[0] <= samp_i;
      for (int i = 1; i < TAPS; i++) dly_q[i] <= dly_q[i-1];
    end
  end

  assign tap_a = dly_q[idx_q];
  assign tap_b = dly_q[TAPS - 1 - int'(idx_q)];
  assign pre   = {tap_a[DW-1], tap_a} + {tap_b[DW-1], tap_b};
  assign prod  = PW'(pre) * PW'(coef_i[idx_q]);
  assign rnd_s = (acc_q + RND) >>> SH;

  always_comb begin
    busy_d = busy_q;
    fin_d  = 1'b0;
    idx_d  = idx_q;
    acc_d  = acc_q;
    out_d  = out_q;
    ov_d   = 1'b0;
    if (samp_valid_i) begin
      busy_d = 1'b1;
      idx_d  = '0;
      acc_d  = '0;
    end else if (busy_q) begin
      acc_d = acc_q + {{(AW-PW){prod[PW-1]}}, prod};
      idx_d = idx_q + 1'b1;
      if (idx_q == LAST) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
      end
    end
    if (fin_q) begin
      ov_d = 1'b1;
      if (rnd_s > OMAX)      out_d = OMAX[DW-1:0];
      else if (rnd_s < OMIN) out_d = OMIN[DW-1:0];
      else                   out_d = rnd_s[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      idx_q  <= '0;
      acc_q  <= '0;
      out_q  <= '0;
      ov_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      fin_q  <= fin_d;
      idx_q  <= idx_d;
      acc_q  <= acc_d;
      out_q  <= out_d;
      ov_q   <= ov_d;
    end
  end

  assign out_valid_o = ov_q;
  assign out_o       = out_q;
endmodule

// File: rtl/afir_ripple_filter.sv
module afir_ripple_filter #(
  parameter int TAPS      = 32,
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int AW        = 40,
  parameter int FW        = 16,
  parameter int FRAC      = 8,
  parameter int NBANDS    = 14,
  parameter int F_MIN_HZ  = 20,
  parameter int BAND_HZ   = 3,
  parameter int HYST_Q    = 64,
  parameter int SAMPLE_HZ = 640
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] freq_i,
  input  logic          samp_valid_i,
  input  logic [DW-1:0] samp_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o,
  output logic [3:0]    out_band_o
);
  localparam int HALF = TAPS / 2;
  localparam int BW   = $clog2(NBANDS);

  logic [1:0]           rs_q;
  logic                 rst_sync_n;
  logic [BW-1:0]        pend_band, act_band;
  logic signed [CW-1:0] coef [HALF];
  logic signed [DW-1:0] mac_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  afir_band_sel #(
    .FW(FW), .FRAC(FRAC), .NBANDS(NBANDS), .F_MIN_HZ(F_MIN_HZ),
    .BAND_HZ(BAND_HZ), .HYST_Q(HYST_Q), .BW(BW)
  ) u_band (
    .clk(clk), .rst_n(rst_sync_n), .freq_i(freq_i), .band_o(pend_band)
  );

  afir_coef_bank #(
    .NBANDS(NBANDS), .HALF(HALF), .CW(CW), .SAMPLE_HZ(SAMPLE_HZ),
    .F_MIN_HZ(F_MIN_HZ), .BAND_HZ(BAND_HZ), .BW(BW)
  ) u_coef (
    .clk(clk), .rst_n(rst_sync_n), .band_i(pend_band), .load_i(samp_valid_i),
    .coef_o(coef), .band_o(act_band)
  );

  afir_mac #(
    .TAPS(TAPS), .DW(DW), .CW(CW), .AW(AW)
  ) u_mac (
    .clk(clk), .rst_n(rst_sync_n), .samp_valid_i(samp_valid_i),
    .samp_i(samp_i), .coef_i(coef), .out_valid_o(out_valid_o), .out_o(mac_out)
  );

  assign out_data_o = mac_out;
  assign out_band_o = 4'(act_band);
endmodule

// File: rtl/afir_ripple_filter_chk.sv
module afir_ripple_filter_chk #(
  parameter int TAPS   = 32,
  parameter int NBANDS = 14,
  parameter int FW     = 16,
  parameter int BW     = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [FW-1:0] freq_i,
  input logic          samp_valid_i,
  input logic          out_valid_o,
  input logic [3:0]    out_band_o,
  input logic [BW-1:0] pend_band
);
  localparam int LAT = TAPS / 2 + 2;

  logic [7:0] lat_q;
  logic [3:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      seen_q <= '0;
    end else begin
      if (seen_q != 4'hF) seen_q <= seen_q + 1'b1;
      if (samp_valid_i)                       lat_q <= 8'd1;
      else if (lat_q != 8'd0 && lat_q != 8'hFF) lat_q <= lat_q + 1'b1;
    end
  end

  assert_out_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |=> !out_valid_o);

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (lat_q == 8'(LAT)));

  assert_band_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_band_o <= 4'(NBANDS - 1));

  assert_band_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q >= 4'd6 && pend_band != $past(pend_band))
      |-> ($past(freq_i) != $past(freq_i, 2)));
endmodule

bind afir_ripple_filter afir_ripple_filter_chk #(
  .TAPS(TAPS), .NBANDS(NBANDS), .FW(FW), .BW($clog2(NBANDS))
) u_chk (
  .clk(clk), .rst_n(rst_n), .freq_i(freq_i), .samp_valid_i(samp_valid_i),
  .out_valid_o(out_valid_o), .out_band_o(out_band_o), .pend_band(pend_band)
);

// File: tb/afir_ripple_filter_bench.sv
`timescale 1ns/1ps
module afir_ripple_filter_bench;
  localparam int GAP = 22;
  localparam int LATC = 18;

  logic        clk;
  logic        rst_n;
  logic [15:0] freq;
  logic        samp_valid;
  logic [15:0] samp;
  logic        out_valid;
  logic [15:0] out_data;
  logic [3:0]  out_band;

  afir_ripple_filter u_afir_ripple_filter (
    .clk(clk), .rst_n(rst_n), .freq_i(freq), .samp_valid_i(samp_valid),
    .samp_i(samp), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_band_o(out_band)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct { int d; int b; longint t; string req; } exp_t;
  exp_t   sbq[$];
  int     nchk = 0;
  int     nfail = 0;
  int     mband = 0;
  int     hist[32];
  longint cyc = 0;
  bit     done = 0;
  int     lcg = 12345;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // R1: raw band from 1/256 Hz units
  function automatic int raw_band(int f);
    int r;
    if (f < 20 * 256) return 0;
    r = (f - 20 * 256) / 768;
    return (r > 13) ? 13 : r;
  endfunction

  // R2: hysteresis around the held band
  function automatic int next_band(int cur, int f);
    int lo;
    bit stay;
    lo = (20 + 3 * cur) * 256;
    stay = (cur == 0 || f >= lo - 64) && (cur == 13 || f < lo + 768 + 64);
    return stay ? cur : raw_band(f);
  endfunction

  // R3/R4: expected output from the model history
  function automatic int model_out(int b);
    int ctr2, hw, c;
    longint s, r;
    ctr2 = 43 + 6 * b;
    hw = (1280 + ctr2) / (2 * ctr2);
    if (hw < 1) hw = 1;
    if (hw > 16) hw = 16;
    c = 32768 / (2 * hw);
    s = 0;
    for (int t = 16 - hw; t <= 15 + hw; t++) s += longint'(hist[t]) * c;
    r = (s + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  function automatic int next_rand();
    lcg = lcg * 1103515245 + 12345;
    return (lcg >>> 8) % 32768;
  endfunction

  task automatic set_freq(input int f);
    @(negedge clk);
    freq = 16'(f);
    mband = next_band(mband, f);
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input int x, input string req, input int fchg);
    exp_t e;
    @(negedge clk);
    for (int i = 31; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    e.d = model_out(mband);
    e.b = mband;
    e.t = cyc;
    e.req = req;
    sbq.push_back(e);
    samp_valid = 1'b1;
    samp = 16'(x);
    @(negedge clk);
    samp_valid = 1'b0;
    repeat (4) @(negedge clk);
    if (fchg >= 0) begin
      freq = 16'(fchg);      // R5: change while the output is being built
      mband = next_band(mband, fchg);
    end
    repeat (GAP - 5) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard as outputs appear
  initial begin
    bit prev_ov;
    exp_t e;
    prev_ov = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (prev_ov) chk(1'b0, "R6 pulse width", 1, 0);
        if (sbq.size() == 0) begin
          chk(1'b0, "R6 unexpected output", int'($signed(out_data)), 0);
        end else begin
          e = sbq.pop_front();
          chk(int'($signed(out_data)) == e.d, e.req, int'($signed(out_data)), e.d);
          chk(int'(out_band) == e.b, "R5 band of set", int'(out_band), e.b);
          chk(cyc - e.t == LATC, "R6 latency", int'(cyc - e.t), LATC);
        end
      end
      prev_ov = out_valid;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) hist[i] = 0;
    rst_n = 1'b0;
    freq = 16'(50 * 256);
    samp_valid = 1'b0;
    samp = '0;
    repeat (4) @(negedge clk);
    // R8: reset state
    chk(out_valid == 1'b0, "R8 out_valid", int'(out_valid), 0);
    chk(out_data == 16'd0, "R8 out_data", int'(out_data), 0);
    chk(out_band == 4'd0, "R8 out_band", int'(out_band), 0);
    rst_n = 1'b1;
    mband = next_band(0, 50 * 256);
    repeat (8) @(negedge clk);

    // R3: impulse response at 50 Hz (band 10)
    send(20000, "R3 impulse b10", -1);
    for (int i = 0; i < 31; i++) send(0, "R3 impulse b10", -1);

    // R1: band index over the range, with mixed data
    set_freq(15 * 256);  send(next_rand(), "R1 below 20 Hz", -1);
    set_freq(20 * 256);  send(-next_rand(), "R1 at 20 Hz", -1);
    set_freq(23 * 256);  send(next_rand(), "R1 at 23 Hz", -1);
    set_freq(61 * 256);  send(-next_rand(), "R1 above 59 Hz", -1);
    set_freq(50 * 256);  send(next_rand(), "R1 at 50 Hz", -1);

    // R2: hysteresis around the 53 Hz edge
    set_freq(13594);     send(next_rand(), "R2 53.10 Hz holds", -1);
    set_freq(13645);     send(next_rand(), "R2 53.30 Hz moves", -1);
    set_freq(13542);     send(-next_rand(), "R2 52.90 Hz holds", -1);
    set_freq(13491);     send(next_rand(), "R2 52.70 Hz moves", -1);

    // R4: full-scale constants, rounding and limits
    set_freq(60 * 256);
    for (int i = 0; i < 24; i++) send(32767, "R4 +full b13", -1);
    set_freq(21 * 256);
    for (int i = 0; i < 32; i++) send(-32768, "R4 -full b0", -1);

    // R5: frequency moves after acceptance; next sample uses the new set
    set_freq(50 * 256);
    send(next_rand(), "R5 swap at boundary", 30 * 256);
    send(next_rand(), "R5 new set", -1);
    send(-next_rand(), "R5 new set", -1);

    // R7: zero-mean inputs with the window period and half of it (band 10, 12 taps)
    set_freq(50 * 256);
    for (int n = 0; n < 48; n++)
      send(((n % 12) < 6) ? 9000 : -9000, (n >= 24) ? "R7 null at f" : "R7 fill", -1);
    for (int n = 0; n < 36; n++)
      send(((n % 6) < 3) ? -7000 : 7000, (n >= 24) ? "R7 null at 2f" : "R7 fill", -1);

    repeat (LATC + 4) @(negedge clk);
    chk(sbq.size() == 0, "R6 outputs missing", sbq.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule